// File: doc/BRIEF.md
# Hashed Page Table Walker

This block searches a hashed page table in memory after a translation lookaside miss. A request carries a 24-bit segment identifier, a 16-bit page index and the access type (instruction or data, load or store, protection violation flagged or not). The request also carries the table base address and the hash mask. The walker derives the primary group address and reads the eight entries of that group one at a time through a single-outstanding read port. The memory may answer after any number of cycles. If no primary entry matches, the walker moves to the secondary group, whose hash is the complement of the primary hash, and scans its eight entries the same way.

A matching entry ends the walk with a hit. The walker presents the entry, with its status bits updated, on a TLB fill port for one cycle. If the referenced and changed status bits in memory need to change, the walker first writes them back in a single write to the entry's second word. When all sixteen entries fail to match, the walk ends in a page fault, tagged as instruction-side or data-side. Caching, TLB storage, exception delivery and protection evaluation are outside the block. The protection-violation verdict arrives as an input with the request.

Top module: `hpt_walker`

## Requirements
- R1: The first read of a walk goes to `tbl_base | ((hash & tbl_mask) << 6)`, where the primary hash is `req_vsid[18:0] ^ {3'b0, req_pidx}`.
- R2: Within a group, entry i is read at group address + 8*i, for i = 0 to 7 in increasing order. Each read completes (`mem_rd_valid`) before the next read starts, whatever the latency.
- R3: Read data bits 63:32 form word 0: valid at bit 31, segment identifier at 30:7, hash-select at 6, abbreviated page index at 5:0. The abbreviated page index is compared with `req_pidx[15:10]`. A primary entry matches only when valid=1, hash-select=0, and both the segment identifier and the abbreviated page index are equal.
- R4: After eight primary misses, the walker reads the secondary group. Its hash is the bitwise complement of the 19-bit primary hash, and the scan starts at entry 0.
- R5: A secondary entry matches only with hash-select=1, under the same valid, segment and index conditions as R3.
- R6: A walk ends with `done` high for one cycle, with exactly one of `hit`/`fault` set. On a hit, `tlb_fill_valid` is high in that cycle. `tlb_fill_hi` then carries word 0, `tlb_fill_lo` carries the updated word 1, and `hit_secondary` names the group that hit.
- R7: Word 1 (read data bits 31:0) has the referenced bit at bit 8. On a hit with referenced=0, the walker writes word 1 with referenced set to group address + 8*i + 4. When no status bit changes, no write takes place.
- R8: Word 1 has the changed bit at bit 7. The walker sets it only for a store with `req_prot_viol`=0. When both the referenced and changed bits change, a single write carries both.
- R9: Sixteen misses end the walk with `fault`=1 and `fault_instr` equal to the request's `req_instr`.
- R10: `req_ready` is high only while idle. A request is taken on `req_valid && req_ready`, after which `busy` stays high and `req_ready` low until `done`.
- R11: Every table read carries `mem_rd_attr` = 3'b001 (cacheable, global, not exclusive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vsid | input | 24 | Segment identifier of the access |
| req_pidx | input | 16 | Page index of the access |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_store | input | 1 | 1 = store access |
| req_prot_viol | input | 1 | Protection violation for this access |
| tbl_base | input | ADDR_W | Page table base address |
| tbl_mask | input | HASH_W | Hash mask |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | ADDR_W | Entry address being read |
| mem_rd_attr | output | 3 | Read attributes |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 64 | Entry: word 0 in 63:32, word 1 in 31:0 |
| mem_wr_req | output | 1 | Status write-back request, held until ack |
| mem_wr_addr | output | ADDR_W | Address of word 1 of the hit entry |
| mem_wr_data | output | 32 | Updated word 1 |
| mem_wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, one cycle |
| hit | output | 1 | Walk found an entry |
| fault | output | 1 | Walk found nothing |
| fault_instr | output | 1 | Fault belongs to an instruction fetch |
| hit_secondary | output | 1 | Hit came from the secondary group |
| tlb_fill_valid | output | 1 | TLB fill strobe |
| tlb_fill_hi | output | 32 | Word 0 of the hit entry |
| tlb_fill_lo | output | 32 | Updated word 1 of the hit entry |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, a 19-bit hash and eight entries per group. It swaps the mask between a narrow 10-bit value on a nonzero base and a full 19-bit mask on a zero base, so both truncation of the hash and the complete secondary complement are exercised. Read latencies of zero and three cycles show that the scan order does not depend on memory timing. The table model places near-miss entries (wrong hash-select, invalid, wrong segment, wrong index) ahead of the true entry, so each match condition is exercised on its own.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table walker.
// Assumes the two-word entry layout below; fields are numbered from bit 0 = LSB.
package hpt_pkg;

    // Word 0 of an entry: identity of the mapped page.
    typedef struct packed {
        logic        valid;     // bit 31
        logic [23:0] vsid;      // bits 30:7
        logic        hsel;      // bit 6, 1 = lives in secondary group
        logic [5:0]  api;       // bits 5:0, top of the page index
    } pte_hi_t;

    // Word 1 of an entry: translation and status.
    typedef struct packed {
        logic [19:0] rpn;       // bits 31:12
        logic [2:0]  rsvd_a;    // bits 11:9
        logic        ref_b;     // bit 8
        logic        chg_b;     // bit 7
        logic [3:0]  wimg;      // bits 6:3
        logic        rsvd_b;    // bit 2
        logic [1:0]  pp;        // bits 1:0
    } pte_lo_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } walk_state_t;

    // Cacheable, global, non-exclusive table read.
    localparam logic [2:0] TBL_RD_ATTR = 3'b001;

endpackage

// File: rtl/hpt_group_addr.sv
// Group address generator.
// Forms the primary hash (low segment bits XOR page index) or its complement
// for the secondary group, masks it and places it above the group offset.
// Assumes the base has zeros where the masked hash lands.
module hpt_group_addr #(
    parameter int ADDR_W    = 32,
    parameter int HASH_W    = 19,
    parameter int VSID_W    = 24,
    parameter int PIDX_W    = 16,
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              secondary,
    input  logic [ADDR_W-1:0] base,
    input  logic [HASH_W-1:0] mask,
    output logic [ADDR_W-1:0] grp_addr
);
    logic [HASH_W-1:0] hash_pri;
    logic [HASH_W-1:0] hash_sel;

    // Hash selection and address composition.
    always_comb begin
        hash_pri = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
        hash_sel = secondary ? ~hash_pri : hash_pri;
        grp_addr = base | (ADDR_W'(hash_sel & mask) << GRP_SHIFT);
    end
endmodule

// File: rtl/hpt_entry_match.sv
// Entry comparator.
// An entry matches when it is valid, its hash-select equals the group being
// scanned and both the segment identifier and abbreviated index agree.
module hpt_entry_match
    import hpt_pkg::*;
(
    input  pte_hi_t     word0,
    input  logic [23:0] vsid,
    input  logic [5:0]  api,
    input  logic        want_sec,
    output logic        match
);
    // Compare all four conditions in parallel.
    always_comb begin
        match = word0.valid
             && (word0.hsel == want_sec)
             && (word0.vsid == vsid)
             && (word0.api  == api);
    end
endmodule

// File: rtl/hpt_rc_update.sv
// Status bit updater.
// Sets the referenced bit always and the changed bit only for stores without a
// protection violation; flags a write when either bit actually changes.
module hpt_rc_update
    import hpt_pkg::*;
(
    input  pte_lo_t word1,
    input  logic    is_store,
    input  logic    prot_viol,
    output pte_lo_t new_word1,
    output logic    need_wr
);
    logic set_chg;

    // Merge both bit updates into one word.
    always_comb begin
        set_chg         = is_store && !prot_viol;
        new_word1       = word1;
        new_word1.ref_b = 1'b1;
        if (set_chg) new_word1.chg_b = 1'b1;
        need_wr = (new_word1 != word1);
    end
endmodule

// File: rtl/hpt_walker.sv
// Hashed page table walker, top level.
// Scans the primary then the secondary eight-entry group, one read in flight,
// writes status back on a hit and reports hit or fault with a one-cycle done.
// Assumes the memory answers every read exactly once and acks every write.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int HASH_W      = 19,
    parameter int GROUP_N     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_vsid,
    input  logic [15:0]       req_pidx,
    input  logic              req_instr,
    input  logic              req_store,
    input  logic              req_prot_viol,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [HASH_W-1:0] tbl_mask,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [2:0]        mem_rd_attr,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              fault,
    output logic              fault_instr,
    output logic              hit_secondary,
    output logic              tlb_fill_valid,
    output logic [31:0]       tlb_fill_hi,
    output logic [31:0]       tlb_fill_lo
);
    localparam int IDX_W     = $clog2(GROUP_N);
    localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT = $clog2(GROUP_N * ENTRY_BYTES);
    localparam logic [ADDR_W-1:0] WORD1_OFS = ADDR_W'(ENTRY_BYTES / 2);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(GROUP_N - 1);

    walk_state_t       state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sec_q;
    logic [23:0]       vsid_q;
    logic [15:0]       pidx_q;
    logic              instr_q, store_q, viol_q;
    logic [ADDR_W-1:0] base_q;
    logic [HASH_W-1:0] mask_q;
    logic              hit_q, fault_q;
    pte_hi_t           hit_hi_q;
    pte_lo_t           hit_lo_q;
    pte_lo_t           orig_lo_q;
    logic [ADDR_W-1:0] wr_addr_q;

    logic [ADDR_W-1:0] grp_addr;
    logic [ADDR_W-1:0] entry_addr;
    logic              ent_match;
    pte_lo_t           upd_lo;
    logic              upd_need;

    hpt_group_addr #(
        .ADDR_W   (ADDR_W),
        .HASH_W   (HASH_W),
        .VSID_W   (24),
        .PIDX_W   (16),
        .GRP_SHIFT(GRP_SHIFT)
    ) u_grp (
        .vsid     (vsid_q),
        .pidx     (pidx_q),
        .secondary(sec_q),
        .base     (base_q),
        .mask     (mask_q),
        .grp_addr (grp_addr)
    );

    hpt_entry_match u_match (
        .word0   (pte_hi_t'(mem_rd_data[63:32])),
        .vsid    (vsid_q),
        .api     (pidx_q[15:10]),
        .want_sec(sec_q),
        .match   (ent_match)
    );

    hpt_rc_update u_rc (
        .word1    (pte_lo_t'(mem_rd_data[31:0])),
        .is_store (store_q),
        .prot_viol(viol_q),
        .new_word1(upd_lo),
        .need_wr  (upd_need)
    );

    // Address of the entry currently being fetched.
    always_comb begin
        entry_addr = grp_addr + (ADDR_W'(idx_q) << ENT_SHIFT);
    end

    // Walk sequencer: request capture, scan, write-back and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            sec_q     <= 1'b0;
            vsid_q    <= '0;
            pidx_q    <= '0;
            instr_q   <= 1'b0;
            store_q   <= 1'b0;
            viol_q    <= 1'b0;
            base_q    <= '0;
            mask_q    <= '0;
            hit_q     <= 1'b0;
            fault_q   <= 1'b0;
            hit_hi_q  <= '0;
            hit_lo_q  <= '0;
            orig_lo_q <= '0;
            wr_addr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vsid_q  <= req_vsid;
                        pidx_q  <= req_pidx;
                        instr_q <= req_instr;
                        store_q <= req_store;
                        viol_q  <= req_prot_viol;
                        base_q  <= tbl_base;
                        mask_q  <= tbl_mask;
                        idx_q   <= '0;
                        sec_q   <= 1'b0;
                        hit_q   <= 1'b0;
                        fault_q <= 1'b0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        if (ent_match) begin
                            hit_q     <= 1'b1;
                            hit_hi_q  <= pte_hi_t'(mem_rd_data[63:32]);
                            hit_lo_q  <= upd_lo;
                            orig_lo_q <= pte_lo_t'(mem_rd_data[31:0]);
                            wr_addr_q <= entry_addr + WORD1_OFS;
                            state_q   <= upd_need ? ST_WRITE : ST_DONE;
                        end else if (idx_q == LAST_IDX) begin
                            if (sec_q) begin
                                fault_q <= 1'b1;
                                state_q <= ST_DONE;
                            end else begin
                                sec_q   <= 1'b1;
                                idx_q   <= '0;
                                state_q <= ST_ISSUE;
                            end
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_WRITE: if (mem_wr_ack) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state and captured results.
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        busy           = (state_q != ST_IDLE);
        mem_rd_req     = (state_q == ST_ISSUE);
        mem_rd_addr    = entry_addr;
        mem_rd_attr    = TBL_RD_ATTR;
        mem_wr_req     = (state_q == ST_WRITE);
        mem_wr_addr    = wr_addr_q;
        mem_wr_data    = hit_lo_q;
        done           = (state_q == ST_DONE);
        hit            = hit_q;
        fault          = fault_q;
        fault_instr    = fault_q && instr_q;
        hit_secondary  = hit_q && sec_q;
        tlb_fill_valid = done && hit_q;
        tlb_fill_hi    = hit_hi_q;
        tlb_fill_lo    = hit_lo_q;
    end

    // Acceptance leaves the walker busy and closed to new requests.
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    // Only one read may be outstanding: no back-to-back requests.
    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // Every write-back carries the referenced bit.
    assert_wr_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wr_data[8]);

    // The changed bit is raised only for an unviolated store.
    assert_chg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_data[7] && !orig_lo_q.chg_b) |-> (store_q && !viol_q));

    // A walk concludes with exactly one outcome.
    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hit ^ fault));

    // A fault only follows the last secondary entry.
    assert_fault_after_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (sec_q && idx_q == LAST_IDX));
endmodule

// File: tb/hpt_walker_bench.sv
// Directed bench for the hashed page table walker.
module hpt_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vsid = '0;
    logic [15:0] req_pidx = '0;
    logic        req_instr = 1'b0, req_store = 1'b0, req_prot_viol = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [18:0] tbl_mask = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic [2:0]  mem_rd_attr;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;
    logic        busy, done, hit, fault, fault_instr, hit_secondary;
    logic        tlb_fill_valid;
    logic [31:0] tlb_fill_hi, tlb_fill_lo;

    int n_chk = 0, n_fail = 0;
    int lat = 0;
    logic [63:0] tbl [int unsigned];
    logic [31:0] rd_log [0:31];
    int rd_cnt = 0;
    int bad_attr = 0;
    int wr_cnt = 0;
    logic [31:0] wr_addr_l, wr_data_l;
    logic d_hit, d_fault, d_finstr, d_sec, d_fill;
    logic [31:0] d_hi, d_lo;

    hpt_walker u_hpt_walker (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic sec);
        logic [18:0] h;
        h = req_vsid[18:0] ^ {3'b000, req_pidx};
        if (sec) h = ~h;
        return tbl_base | ({13'd0, h & tbl_mask} << 6);
    endfunction

    function automatic logic [31:0] mk_hi(input logic v, input logic [23:0] vs, input logic h, input logic [5:0] api);
        return {v, vs, h, api};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [19:0] rpn, input logic r, input logic c);
        return {rpn, 3'b000, r, c, 4'b0010, 1'b0, 2'b10};
    endfunction

    task automatic put(input logic sec, input int i, input logic [31:0] hi, input logic [31:0] lo);
        tbl[grp(sec) + 32'(8 * i)] = {hi, lo};
    endtask

    // Memory model: answers reads after lat extra cycles, acks writes at once.
    task automatic responder();
        forever begin
            @(negedge clk);
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_wr_req) begin
                wr_cnt++;
                wr_addr_l = mem_wr_addr;
                wr_data_l = mem_wr_data;
                mem_wr_ack = 1'b1;
            end
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            if (mem_rd_req) begin
                logic [63:0] d;
                if (rd_cnt < 32) rd_log[rd_cnt] = mem_rd_addr;
                rd_cnt++;
                if (mem_rd_attr != 3'b001) bad_attr++;
                d = tbl.exists(mem_rd_addr) ? tbl[mem_rd_addr] : 64'd0;
                repeat (lat + 1) @(negedge clk);
                mem_rd_data  = d;
                mem_rd_valid = 1'b1;
            end
        end
    endtask

    // Offer one request, check the handshake, wait for done, capture results.
    task automatic walk(input logic instr, input logic store, input logic viol);
        int t = 0;
        rd_cnt = 0; wr_cnt = 0; bad_attr = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
        req_instr = instr; req_store = store; req_prot_viol = viol;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2'b10);
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
            if (!done && (req_ready || !busy)) chk(0, "R10 busy until done", {busy, req_ready}, 2'b10);
        end
        chk(done == 1'b1, "R6 walk completes", done, 1);
        d_hit = hit; d_fault = fault; d_finstr = fault_instr; d_sec = hit_secondary;
        d_fill = tlb_fill_valid; d_hi = tlb_fill_hi; d_lo = tlb_fill_lo;
        chk(bad_attr == 0, "R11 read attribute 001", bad_attr, 0);
        @(negedge clk);
        chk(!done && req_ready, "R6 done lasts one cycle", {done, req_ready}, 2'b01);
    endtask

    task automatic chk_order(input int first, input int n, input logic sec, input string req);
        for (int i = 0; i < n; i++)
            chk(rd_log[first + i] == grp(sec) + 32'(8 * i), req, rd_log[first + i], grp(sec) + 32'(8 * i));
    endtask

    task automatic t_reset();
        chk(req_ready && !busy && !done && !mem_rd_req && !mem_wr_req, "R10 reset state",
            {req_ready, busy, done, mem_rd_req, mem_wr_req}, 5'b10000);
    endtask

    // Primary hit behind one near-miss of each kind; referenced bit written.
    task automatic t_primary_hit();
        logic [31:0] good_hi, lo;
        tbl.delete();
        lat = 0;
        tbl_base = 32'h0040_0000; tbl_mask = 19'h003FF;
        req_vsid = 24'h12_3456; req_pidx = 16'hABCD;
        good_hi = mk_hi(1, req_vsid, 0, req_pidx[15:10]);
        lo = mk_lo(20'hBEEF1, 0, 0);
        put(0, 0, mk_hi(1, req_vsid, 0, req_pidx[15:10] ^ 6'd1), lo);
        put(0, 1, mk_hi(1, req_vsid, 1, req_pidx[15:10]), lo);
        put(0, 2, mk_hi(0, req_vsid, 0, req_pidx[15:10]), lo);
        put(0, 3, mk_hi(1, req_vsid ^ 24'h80_0000, 0, req_pidx[15:10]), lo);
        put(0, 4, good_hi, lo);
        walk(0, 0, 0);
        chk(rd_log[0] == grp(0), "R1 primary group address", rd_log[0], grp(0));
        chk(rd_cnt == 5, "R3 near-misses skipped, hit at entry 4", rd_cnt, 5);
        chk_order(0, 5, 0, "R2 primary scan order");
        chk(d_hit && !d_fault && d_fill && !d_sec, "R6 primary hit outcome", {d_hit, d_fault, d_fill, d_sec}, 4'b1010);
        chk(d_hi == good_hi, "R6 fill word 0", d_hi, good_hi);
        chk(d_lo == (lo | 32'h100), "R6 fill word 1 updated", d_lo, lo | 32'h100);
        chk(wr_cnt == 1, "R7 one write-back", wr_cnt, 1);
        chk(wr_addr_l == grp(0) + 32'd36, "R7 write to word 1", wr_addr_l, grp(0) + 32'd36);
        chk(wr_data_l == (lo | 32'h100), "R7 referenced set, changed kept for load", wr_data_l, lo | 32'h100);
    endtask

    // Secondary hit with slow memory; hash-select guards both groups.
    task automatic t_secondary_hit();
        logic [31:0] lo;
        tbl.delete();
        lat = 3;
        tbl_base = 32'h0; tbl_mask = 19'h7FFFF;
        req_vsid = 24'hC0_FFEE; req_pidx = 16'h1357;
        lo = mk_lo(20'h0A5A5, 1, 0);
        put(0, 5, mk_hi(1, req_vsid, 1, req_pidx[15:10]), lo);
        put(1, 0, mk_hi(1, req_vsid, 0, req_pidx[15:10]), lo);
        put(1, 2, mk_hi(1, req_vsid, 1, req_pidx[15:10]), lo);
        walk(0, 1, 0);
        chk(rd_cnt == 11, "R5 secondary hit after H=0 entry skipped", rd_cnt, 11);
        chk(rd_log[8] == grp(1), "R4 secondary group address", rd_log[8], grp(1));
        chk_order(8, 3, 1, "R4 secondary scan order");
        chk_order(0, 8, 0, "R2 primary order under latency");
        chk(d_hit && d_sec, "R6 hit flagged secondary", {d_hit, d_sec}, 2'b11);
        chk(wr_cnt == 1 && wr_data_l == (lo | 32'h080), "R8 changed set for store", wr_data_l, lo | 32'h080);
    endtask

    // Store with violation and already-referenced entry: no write at all.
    task automatic t_no_write();
        logic [31:0] lo;
        tbl.delete();
        lat = 1;
        tbl_base = 32'h0040_0000; tbl_mask = 19'h003FF;
        req_vsid = 24'h00_0042; req_pidx = 16'hF00F;
        lo = mk_lo(20'h12345, 1, 0);
        put(0, 0, mk_hi(1, req_vsid, 0, req_pidx[15:10]), lo);
        walk(0, 1, 1);
        chk(d_hit && wr_cnt == 0, "R8 no changed update under violation", wr_cnt, 0);
        chk(d_lo == lo, "R8 fill keeps changed clear", d_lo, lo);
        lo = mk_lo(20'h12345, 1, 1);
        put(0, 0, mk_hi(1, req_vsid, 0, req_pidx[15:10]), lo);
        walk(0, 0, 0);
        chk(d_hit && wr_cnt == 0, "R7 no write when bits already set", wr_cnt, 0);
    endtask

    // Store hit with both bits clear: one write sets both.
    task automatic t_both_bits();
        logic [31:0] lo;
        tbl.delete();
        lat = 0;
        req_vsid = 24'h7F_0001; req_pidx = 16'h0400;
        lo = mk_lo(20'hFFFFF, 0, 0);
        put(0, 7, mk_hi(1, req_vsid, 0, req_pidx[15:10]), lo);
        walk(1, 1, 0);
        chk(wr_cnt == 1, "R8 single combined write", wr_cnt, 1);
        chk(wr_data_l == (lo | 32'h180), "R8 referenced and changed together", wr_data_l, lo | 32'h180);
        chk(wr_addr_l == grp(0) + 32'd60, "R7 write address of last entry", wr_addr_l, grp(0) + 32'd60);
    endtask

    // Empty table: sixteen reads then a fault of the request's side.
    task automatic t_fault(input logic instr);
        tbl.delete();
        lat = 2;
        req_vsid = 24'h3C_3C3C; req_pidx = 16'h5A5A;
        walk(instr, 0, 0);
        chk(rd_cnt == 16, "R9 all sixteen entries read", rd_cnt, 16);
        chk(rd_log[15] == grp(1) + 32'd56, "R4 last secondary entry", rd_log[15], grp(1) + 32'd56);
        chk(d_fault && !d_hit && !d_fill, "R9 fault outcome", {d_fault, d_hit, d_fill}, 3'b100);
        chk(d_finstr == instr, "R9 fault side", d_finstr, instr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        fork responder(); join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_hit();
        t_secondary_hit();
        t_no_write();
        t_both_bits();
        t_fault(1'b1);
        t_fault(1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule